// File: doc/BRIEF.md
# Three-Bank Event Interrupt Aggregator

This block gathers single-cycle event strobes from up to `NBANK * BANK_W` peripheral sources (96 with the default sizes) and latches each one as a pending flag. The flags sit in banks of `BANK_W` bits. Three independent mask sets, each holding one mask word per bank, decide which pending flags reach each of three level interrupt lines. A pending flag can reach several lines at once.

Software reads every pending and mask word through a small register port. It can write the mask words. It can write a pending word to clear the flags where it writes 1, with one exception: a single protected flag, used for the disk DMA completion, can only be removed by the hardware clear strobe. A hardware clear strobe names one event and removes that one flag. Each interrupt line is a registered level. It stays high while any pending flag in any bank is enabled in that line's mask set.

Top module: `event_irq_agg`

## Requirements
- R1: An event number splits into a bank field (bits [6:5]) and a bit-within-bank field (bits [4:0]). A bank field equal to 3, where no bank exists, changes no pending flag and no interrupt line.
- R2: When `raise_vld` is high, the flag named by `raise_id` is set on the next clock edge. It stays set until it is cleared.
- R3: Line `irq[0]` follows mask set A, `irq[1]` follows set B and `irq[2]` follows set C. Each line rises one clock after a pending flag and its mask bit in the same bank are both set. Since the flag itself takes one clock, the line is high two edges after a raise strobe.
- R4: A register write to a pending word (address 0, 1 or 2 = bank) clears exactly the flags whose write-data bits are 1 and leaves the others untouched.
- R5: Flag 0 of bank 1 (event 0x20) is not cleared by a register write. Only a hardware clear removes it.
- R6: An interrupt line falls only when pending AND mask is zero in every bank for its set. Clearing one contributing flag while another remains keeps the line high.
- R7: When `hclr_vld` is high, only the flag named by `hclr_id` is cleared on the next clock edge.
- R8: `reg_rdata` is registered. It shows the word at the `reg_addr` presented in the previous cycle. Address bits [3:2] select the kind (0 pending, 1 mask A, 2 mask B, 3 mask C) and bits [1:0] select the bank. Written mask words read back unchanged, and a bank value of 3 reads as zero.
- R9: A mask change while a flag is pending moves the interrupt line one clock after the mask word is written.
- R10: If the same flag is raised and cleared in the same cycle, by hardware clear or by register write, the raise wins and the flag ends up set.
- R11: Synchronous active-high reset clears every pending flag, every mask word, the interrupt lines and `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_vld | input | 1 | Event raise strobe |
| raise_id | input | 7 | Event number to raise (bank, bit) |
| hclr_vld | input | 1 | Hardware clear strobe |
| hclr_id | input | 7 | Event number to clear |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address (kind, bank) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 3 | Level interrupt lines for mask sets A, B, C |

## Verification
The bench builds the block with its default sizes: three banks of 32 flags and the protected flag at bank 1, bit 0. At these sizes the bank field of the event number can take the value 3, so the bench can raise an event aimed at a bank that does not exist. The outermost flag (bank 2, bit 31) and the protected flag are both reachable. The bench also drives raise/clear collisions on the same flag, masks that change while flags are pending, and a line that stays high while other banks still contribute to it.

// File: rtl/evagg_pkg.sv
package evagg_pkg;
  typedef enum logic [1:0] {
    KIND_PEND = 2'd0,
    KIND_MSKA = 2'd1,
    KIND_MSKB = 2'd2,
    KIND_MSKC = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/evagg_pend_bank.sv
module evagg_pend_bank #(
  parameter int BANK_W   = 32,
  parameter bit PROT_EN  = 1'b0,
  parameter int PROT_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] set_vec,
  input  logic [BANK_W-1:0] hw_clr_vec,
  input  logic [BANK_W-1:0] sw_clr_vec,
  output logic [BANK_W-1:0] pend_q
);
  logic [BANK_W-1:0] keep_mask;
  logic [BANK_W-1:0] sw_eff;

  generate
    if (PROT_EN) begin : g_prot
      assign keep_mask = BANK_W'(1) << PROT_BIT;
    end else begin : g_noprot
      assign keep_mask = '0;
    end
  endgenerate

  assign sw_eff = sw_clr_vec & ~keep_mask;

  // raise takes priority over any clear of the same flag
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~(sw_eff | hw_clr_vec)) | set_vec;
  end
endmodule

// File: rtl/evagg_irq_level.sv
module evagg_irq_level #(
  parameter int NBANK  = 3,
  parameter int BANK_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NBANK*BANK_W-1:0] pend_flat,
  input  logic [NBANK*BANK_W-1:0] mask_flat,
  output logic                    irq_q
);
  logic hit;
  always_comb hit = |(pend_flat & mask_flat);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= hit;
  end
endmodule

// File: rtl/event_irq_agg.sv
module event_irq_agg #(
  parameter int NBANK     = 3,
  parameter int BANK_W    = 32,
  parameter int NSET      = 3,
  parameter int PROT_BANK = 1,
  parameter int PROT_BIT  = 0,
  localparam int BIT_W    = $clog2(BANK_W),
  localparam int BSEL_W   = $clog2(NBANK),
  localparam int ID_W     = BSEL_W + BIT_W,
  localparam int KIND_W   = 2,
  localparam int ADDR_W   = KIND_W + BSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raise_vld,
  input  logic [ID_W-1:0]   raise_id,
  input  logic              hclr_vld,
  input  logic [ID_W-1:0]   hclr_id,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BANK_W-1:0] reg_wdata,
  output logic [BANK_W-1:0] reg_rdata,
  output logic [NSET-1:0]   irq
);
  import evagg_pkg::*;

  logic [BSEL_W-1:0] r_bank, h_bank, a_bank;
  logic [BIT_W-1:0]  r_bit, h_bit;
  logic [KIND_W-1:0] a_kind;

  assign r_bank = raise_id[ID_W-1:BIT_W];
  assign r_bit  = raise_id[BIT_W-1:0];
  assign h_bank = hclr_id[ID_W-1:BIT_W];
  assign h_bit  = hclr_id[BIT_W-1:0];
  assign a_bank = reg_addr[BSEL_W-1:0];
  assign a_kind = reg_addr[ADDR_W-1:BSEL_W];

  logic [BANK_W-1:0]       pend_q [NBANK];
  logic [BANK_W-1:0]       mask_q [NSET][NBANK];
  logic [NBANK*BANK_W-1:0] pend_flat;
  logic [NBANK*BANK_W-1:0] mask_flat [NSET];
  logic [BANK_W-1:0]       rd_mux;

  genvar b, s;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      logic [BANK_W-1:0] set_vec, hw_vec, sw_vec;
      assign set_vec = (raise_vld && r_bank == BSEL_W'(b)) ? (BANK_W'(1) << r_bit) : '0;
      assign hw_vec  = (hclr_vld && h_bank == BSEL_W'(b)) ? (BANK_W'(1) << h_bit) : '0;
      assign sw_vec  = (reg_wr && a_kind == KIND_PEND && a_bank == BSEL_W'(b)) ? reg_wdata : '0;

      evagg_pend_bank #(
        .BANK_W  (BANK_W),
        .PROT_EN (b == PROT_BANK),
        .PROT_BIT(PROT_BIT)
      ) u_pend (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_vec),
        .hw_clr_vec(hw_vec),
        .sw_clr_vec(sw_vec),
        .pend_q    (pend_q[b])
      );
      assign pend_flat[b*BANK_W +: BANK_W] = pend_q[b];
    end

    for (s = 0; s < NSET; s++) begin : g_set
      for (b = 0; b < NBANK; b++) begin : g_mbank
        always_ff @(posedge clk) begin
          if (rst)
            mask_q[s][b] <= '0;
          else if (reg_wr && a_kind == KIND_W'(s + 1) && a_bank == BSEL_W'(b))
            mask_q[s][b] <= reg_wdata;
        end
        assign mask_flat[s][b*BANK_W +: BANK_W] = mask_q[s][b];
      end

      evagg_irq_level #(
        .NBANK (NBANK),
        .BANK_W(BANK_W)
      ) u_lvl (
        .clk      (clk),
        .rst      (rst),
        .pend_flat(pend_flat),
        .mask_flat(mask_flat[s]),
        .irq_q    (irq[s])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (a_bank == BSEL_W'(i)) begin
        if (a_kind == KIND_PEND) rd_mux = pend_q[i];
        for (int j = 0; j < NSET; j++)
          if (a_kind == KIND_W'(j + 1)) rd_mux = mask_q[j][i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/evagg_chk.sv
module evagg_chk #(
  parameter int NBANK     = 3,
  parameter int BANK_W    = 32,
  parameter int NSET      = 3,
  parameter int BIT_W     = 5,
  parameter int ID_W      = 7,
  parameter int PROT_BANK = 1,
  parameter int PROT_BIT  = 0
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    raise_vld,
  input logic [ID_W-1:0]         raise_id,
  input logic                    hclr_vld,
  input logic [ID_W-1:0]         hclr_id,
  input logic                    reg_wr,
  input logic [NSET-1:0]         irq,
  input logic [NBANK*BANK_W-1:0] pend_flat
);
  localparam int PIDX = PROT_BANK * BANK_W + PROT_BIT;
  localparam logic [ID_W-1:0] PROT_ID = ID_W'(PIDX);

  int unsigned r_bank, r_idx, h_bank, h_idx;
  always_comb begin
    r_bank = int'(raise_id[ID_W-1:BIT_W]);
    r_idx  = r_bank * BANK_W + int'(raise_id[BIT_W-1:0]);
    h_bank = int'(hclr_id[ID_W-1:BIT_W]);
    h_idx  = h_bank * BANK_W + int'(hclr_id[BIT_W-1:0]);
  end

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (rst)
    raise_vld && (r_bank < NBANK) |=> pend_flat[$past(r_idx)]); // R2

  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (rst)
    pend_flat[PIDX] && !(hclr_vld && hclr_id == PROT_ID) |=> pend_flat[PIDX]); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (pend_flat == '0) |=> (irq == '0)); // R6

  AST_NOBANK_STABLE: assert property (@(posedge clk) disable iff (rst)
    raise_vld && (r_bank >= NBANK) && !hclr_vld && !reg_wr |=> $stable(pend_flat)); // R1

  AST_HCLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    hclr_vld && (h_bank < NBANK) && !(raise_vld && raise_id == hclr_id)
    |=> !pend_flat[$past(h_idx)]); // R7
endmodule

bind event_irq_agg evagg_chk #(
  .NBANK    (NBANK),
  .BANK_W   (BANK_W),
  .NSET     (NSET),
  .BIT_W    (BIT_W),
  .ID_W     (ID_W),
  .PROT_BANK(PROT_BANK),
  .PROT_BIT (PROT_BIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .raise_vld(raise_vld),
  .raise_id (raise_id),
  .hclr_vld (hclr_vld),
  .hclr_id  (hclr_id),
  .reg_wr   (reg_wr),
  .irq      (irq),
  .pend_flat(pend_flat)
);

// File: tb/tb_event_irq_agg.sv
`timescale 1ns/1ps
module tb_event_irq_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        raise_vld = 1'b0;
  logic [6:0]  raise_id = '0;
  logic        hclr_vld = 1'b0;
  logic [6:0]  hclr_id = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq;

  event_irq_agg dut (
    .clk(clk), .rst(rst), .raise_vld(raise_vld), .raise_id(raise_id),
    .hclr_vld(hclr_vld), .hclr_id(hclr_id), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference model
  logic [31:0] m_pend [3];
  logic [31:0] m_mask [3][3];

  function automatic logic [2:0] m_irq();
    logic [2:0] r = '0;
    for (int s = 0; s < 3; s++)
      for (int b = 0; b < 3; b++)
        if ((m_pend[b] & m_mask[s][b]) != 0) r[s] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard for register reads
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_issue = 1'b0;
  logic        rd_cap = 1'b0;

  always @(posedge clk) rd_cap <= rd_issue;
  always @(negedge clk) begin
    if (rd_cap && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, reg_rdata, e);
    end
  end

  task automatic rd(logic [3:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    reg_addr = a; rd_issue = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic m_apply(bit rv, logic [6:0] rid, bit hv, logic [6:0] hid,
                         bit wv, logic [3:0] a, logic [31:0] d);
    logic [31:0] clr [3];
    for (int b = 0; b < 3; b++) clr[b] = '0;
    if (hv && hid[6:5] < 3) clr[hid[6:5]] |= 32'd1 << hid[4:0];
    if (wv && a[1:0] < 3) begin
      if (a[3:2] == 0) clr[a[1:0]] |= (a[1:0] == 1) ? (d & ~32'd1) : d;
      else m_mask[a[3:2]-1][a[1:0]] = d;
    end
    for (int b = 0; b < 3; b++) m_pend[b] &= ~clr[b];
    if (rv && rid[6:5] < 3) m_pend[rid[6:5]] |= 32'd1 << rid[4:0];
  endtask

  task automatic drive(bit rv, logic [6:0] rid, bit hv, logic [6:0] hid,
                       bit wv, logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    raise_vld = rv; raise_id = rid; hclr_vld = hv; hclr_id = hid;
    reg_wr = wv; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    raise_vld = 0; hclr_vld = 0; reg_wr = 0;
    m_apply(rv, rid, hv, hid, wv, a, d);
  endtask

  task automatic raise(logic [6:0] id); drive(1, id, 0, 0, 0, 0, 0); endtask
  task automatic hclr(logic [6:0] id);  drive(0, 0, 1, id, 0, 0, 0); endtask
  task automatic wr(logic [3:0] a, logic [31:0] d); drive(0, 0, 0, 0, 1, a, d); endtask

  // irq is registered from pending/mask state: valid one edge later
  task automatic chk_irq(string tag);
    @(negedge clk);
    chk(tag, {29'd0, irq}, {29'd0, m_irq()});
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 3; b++) begin
      m_pend[b] = '0;
      for (int s = 0; s < 3; s++) m_mask[s][b] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 irq", {29'd0, irq}, 32'd0);
    rd(4'h0, 32'd0, "R11 pend0");
    rd(4'h4, 32'd0, "R11 maskA0");

    // R8 mask readback, R2/R3 raise reaches line A
    wr(4'h4, 32'h0000_0010);
    rd(4'h4, 32'h0000_0010, "R8 maskA0");
    raise(7'h04);
    chk_irq("R3 irqA after raise");
    rd(4'h0, 32'h0000_0010, "R2 pend0");

    // line B via bank 2 bit 31
    wr(4'hA, 32'h8000_0000);
    raise(7'h5F);
    chk_irq("R3 irqB bank2");
    rd(4'h2, 32'h8000_0000, "R2 pend2 bit31");

    // line C via protected flag
    wr(4'hD, 32'h0000_0001);
    rd(4'hD, 32'h0000_0001, "R8 maskC1");
    raise(7'h20);
    chk_irq("R3 irqC");

    // R5 software cannot clear protected flag
    wr(4'h1, 32'hFFFF_FFFF);
    rd(4'h1, 32'h0000_0001, "R5 pend1 protected");
    chk_irq("R5 irqC held");

    // R4 write-1-to-clear exactly
    raise(7'h21);
    raise(7'h22);
    wr(4'h1, 32'h0000_0002);
    rd(4'h1, 32'h0000_0005, "R4 pend1");

    // R7 hardware clear of protected flag
    hclr(7'h20);
    rd(4'h1, 32'h0000_0004, "R7 pend1");
    chk_irq("R7 irqC drops");

    // R6 line A held while another bank contributes
    wr(4'h5, 32'h0000_0004);
    wr(4'h0, 32'h0000_0010);
    chk_irq("R6 irqA still high");
    wr(4'h1, 32'h0000_0004);
    chk_irq("R6 irqA falls");

    // R9 mask change while pending
    wr(4'h6, 32'h8000_0000);
    chk_irq("R9 irqA rises on mask");
    wr(4'h6, 32'h0000_0000);
    chk_irq("R9 irqA falls on mask");

    // R1 nonexistent bank
    raise(7'h7F);
    rd(4'h0, m_pend[0], "R1 pend0 untouched");
    rd(4'h1, m_pend[1], "R1 pend1 untouched");
    rd(4'h2, m_pend[2], "R1 pend2 untouched");
    rd(4'h3, 32'd0, "R8 bank3 reads zero");
    chk_irq("R1 irq untouched");

    // R10 raise wins over clears
    drive(1, 7'h45, 1, 7'h45, 0, 0, 0);
    rd(4'h2, 32'h8000_0020, "R10 raise vs hclr");
    drive(1, 7'h03, 0, 0, 1, 4'h0, 32'h0000_0008);
    rd(4'h0, 32'h0000_0008, "R10 raise vs sw clear");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule